// File: doc/BRIEF.md
# Baseline 12-bit Instruction Execute ALU

This block is the data path of a small 8-bit controller core that uses 12-bit instruction words. It takes one instruction word and decodes it. It then combines the working register W, the addressed file-register operand and the incoming carry flag into a result. The outputs tell the rest of the core where that result goes and whether it is written at all. They also give the new carry, digit-carry and zero flags, together with a mask that names which of these flags the instruction is allowed to change.

The block is purely combinational and holds no state. Instruction fetch, the program counter, register-file storage, sleep and the watchdog stay outside the block. Branch, skip, call, return and special-register instructions are still recognised, but only so that they can be reported on a separate "not for this unit" output. For those instructions the block requests no write and changes no flag.

The data width, instruction width and file-address width are parameters, checked at elaboration. A parameter also selects one of two adder structures.

Top module: `base12_exec_alu`

## Requirements
- R1: Add (instruction bits 11:6 = 000111) yields f + W. C is the carry out of bit 7, DC is the carry out of bit 3 into bit 4, and Z is set when the 8-bit result is zero. The mask enables all three flags.
- R2: Subtract (bits 11:6 = 000010) yields f − W. C is 1 when no borrow occurs, DC is 1 when no borrow occurs out of bit 3, and Z is set on a zero result. The mask enables all three flags.
- R3: For the register-operand forms, instruction bit 5 chooses the destination: 0 sends the result to W (dest_f_o = 0) and 1 sends it to the file register (dest_f_o = 1). Every ALU instruction asserts wr_en_o.
- R4: The following operations change only Z. Each is given by its bits 11:6: OR 000100, AND 000101, XOR 000110, move-f 001000, complement 001001, increment 001010, decrement 000011.
- R5: Rotate right (001100) and rotate left (001101) move the operand one place through the incoming carry. The bit shifted out becomes the new C, and only C is enabled.
- R6: Nibble swap (001110) exchanges the upper and lower 4 bits of f and enables no flag.
- R7: Bit clear (bits 11:8 = 0100) and bit set (0101) alter only the bit of f indexed by bits 7:5. The result always goes to the file register, and no flag is enabled.
- R8: Literal operations take bits 7:0 as the operand and always write W. Load literal (bits 11:8 = 1100) enables no flag. OR-literal (1101), AND-literal (1110) and XOR-literal (1111) enable Z only.
- R9: When bits 11:6 = 000001, the result is zero and Z is set. Bit 5 = 0 is the W-clearing form and bit 5 = 1 the file-clearing form. Bits 11:5 = 0000001 copies W to the file register with no flag enabled.
- R10: A set of instruction words is reported with non_alu_o = 1, wr_en_o = 0, a zero mask and a zero result. The set is: bits 11:5 = 0000000 with a nonzero word, bits 11:6 = 001011 or 001111, bits 11:9 = 011, and bits 11:10 = 10. The all-zero word is a no-operation, with non_alu_o = 0, wr_en_o = 0 and a zero mask.
- R11: flag_mask_o bit 2 enables C, bit 1 enables DC and bit 0 enables Z. A flag output whose mask bit is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | Addressed file-register operand |
| c_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result value |
| dest_f_o | output | 1 | 1 = file register, 0 = W |
| wr_en_o | output | 1 | Result is to be written |
| c_o | output | 1 | New carry flag |
| dc_o | output | 1 | New digit-carry flag |
| z_o | output | 1 | New zero flag |
| flag_mask_o | output | 3 | Flag update enables {C, DC, Z} |
| non_alu_o | output | 1 | Instruction is not handled by this unit |

## Verification
Directed words target the carry boundaries. Adding 0x80 to 0x80 separates the carry from the zero flag. Adding 0x0F and 0x01 raises only the digit carry. Subtracting equal values and subtracting 1 from 0 give the no-borrow and borrow cases, in the full byte and in the low nibble. Rotates are run with each carry-in value, and bit set and bit clear at both end bit positions, which exposes a wrong index or a wrong shift direction. Random instruction words drawn over the whole 12-bit space, with random operands and carry, cover every opcode group including the control words. These words catch decode overlaps, wrong destination bits and flags that are enabled when they should not be.

// File: rtl/base12_alu_pkg.sv
package base12_alu_pkg;

   localparam int FLG_C  = 2;
   localparam int FLG_DC = 1;
   localparam int FLG_Z  = 0;

   typedef enum logic [4:0] {
      K_NONE, K_ADD, K_SUB, K_INC, K_DEC,
      K_AND, K_OR, K_XOR, K_COM, K_PASS,
      K_RR, K_RL, K_SWAP, K_BCLR, K_BSET,
      K_TAKEW, K_ZERO
   } alu_kind_e;

   typedef struct packed {
      logic      non_alu;
      logic      wr_en;
      logic      dest_f;
      logic      use_lit;
      logic [2:0] mask;
      alu_kind_e kind;
   } dec_s;

endpackage

// File: rtl/base12_alu_decode.sv
module base12_alu_decode
   import base12_alu_pkg::*;
#(
   parameter int INSTR_W = 12
) (
   input  logic [INSTR_W-1:0] instr_i,
   output dec_s               dec_o
);

   localparam int TOP = INSTR_W - 1;

   if (INSTR_W != 12) begin : g_bad_iw
      $error("base12_alu_decode: INSTR_W must be 12");
   end

   logic [5:0] op6;
   logic [3:0] op4;
   logic       dbit;

   assign op6  = instr_i[TOP -: 6];
   assign op4  = instr_i[TOP -: 4];
   assign dbit = instr_i[5];

   always_comb begin
      dec_o = '{non_alu: 1'b0, wr_en: 1'b1, dest_f: dbit, use_lit: 1'b0,
                mask: 3'b000, kind: K_NONE};
      unique case (op4)
         4'b0000, 4'b0001, 4'b0010, 4'b0011: begin
            unique case (op6)
               6'b000000: begin
                  if (dbit) begin
                     dec_o.kind   = K_TAKEW;
                     dec_o.dest_f = 1'b1;
                  end else begin
                     dec_o.wr_en   = 1'b0;
                     dec_o.dest_f  = 1'b0;
                     dec_o.non_alu = (instr_i != '0);
                  end
               end
               6'b000001: begin dec_o.kind = K_ZERO; dec_o.mask = 3'b001; end
               6'b000010: begin dec_o.kind = K_SUB;  dec_o.mask = 3'b111; end
               6'b000011: begin dec_o.kind = K_DEC;  dec_o.mask = 3'b001; end
               6'b000100: begin dec_o.kind = K_OR;   dec_o.mask = 3'b001; end
               6'b000101: begin dec_o.kind = K_AND;  dec_o.mask = 3'b001; end
               6'b000110: begin dec_o.kind = K_XOR;  dec_o.mask = 3'b001; end
               6'b000111: begin dec_o.kind = K_ADD;  dec_o.mask = 3'b111; end
               6'b001000: begin dec_o.kind = K_PASS; dec_o.mask = 3'b001; end
               6'b001001: begin dec_o.kind = K_COM;  dec_o.mask = 3'b001; end
               6'b001010: begin dec_o.kind = K_INC;  dec_o.mask = 3'b001; end
               6'b001100: begin dec_o.kind = K_RR;   dec_o.mask = 3'b100; end
               6'b001101: begin dec_o.kind = K_RL;   dec_o.mask = 3'b100; end
               6'b001110: begin dec_o.kind = K_SWAP; end
               default: begin
                  dec_o.non_alu = 1'b1;
                  dec_o.wr_en   = 1'b0;
                  dec_o.dest_f  = 1'b0;
               end
            endcase
         end
         4'b0100: begin dec_o.kind = K_BCLR; dec_o.dest_f = 1'b1; end
         4'b0101: begin dec_o.kind = K_BSET; dec_o.dest_f = 1'b1; end
         4'b1100: begin
            dec_o.kind = K_PASS; dec_o.use_lit = 1'b1; dec_o.dest_f = 1'b0;
         end
         4'b1101: begin
            dec_o.kind = K_OR; dec_o.use_lit = 1'b1; dec_o.dest_f = 1'b0;
            dec_o.mask = 3'b001;
         end
         4'b1110: begin
            dec_o.kind = K_AND; dec_o.use_lit = 1'b1; dec_o.dest_f = 1'b0;
            dec_o.mask = 3'b001;
         end
         4'b1111: begin
            dec_o.kind = K_XOR; dec_o.use_lit = 1'b1; dec_o.dest_f = 1'b0;
            dec_o.mask = 3'b001;
         end
         default: begin
            dec_o.non_alu = 1'b1;
            dec_o.wr_en   = 1'b0;
            dec_o.dest_f  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/base12_alu_addsub.sv
module base12_alu_addsub #(
   parameter int DATA_W      = 8,
   parameter int SPLIT_ADDER = 0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              half_o
);

   localparam int NIB = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_dw
      $error("base12_alu_addsub: DATA_W must be even");
   end

   if (SPLIT_ADDER != 0) begin : g_split
      logic [NIB:0]        lo;
      logic [DATA_W-NIB:0] hi;
      always_comb begin
         lo = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
         hi = {1'b0, a_i[DATA_W-1:NIB]} + {1'b0, b_i[DATA_W-1:NIB]}
              + {{(DATA_W-NIB){1'b0}}, lo[NIB]};
      end
      assign sum_o  = {hi[DATA_W-NIB-1:0], lo[NIB-1:0]};
      assign cout_o = hi[DATA_W-NIB];
      assign half_o = lo[NIB];
   end else begin : g_flat
      logic [DATA_W:0] full;
      logic [NIB:0]    part;
      always_comb begin
         full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
         part = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
      end
      assign sum_o  = full[DATA_W-1:0];
      assign cout_o = full[DATA_W];
      assign half_o = part[NIB];
   end

endmodule

// File: rtl/base12_alu_logic.sv
module base12_alu_logic
   import base12_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BSEL_W = $clog2(DATA_W)
) (
   input  alu_kind_e         kind_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              c_i,
   input  logic [BSEL_W-1:0] bsel_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o
);

   localparam int NIB = DATA_W / 2;

   logic [DATA_W-1:0] onehot;
   assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bsel_i;

   always_comb begin
      res_o = '0;
      c_o   = 1'b0;
      unique case (kind_i)
         K_AND:   res_o = w_i & opnd_i;
         K_OR:    res_o = w_i | opnd_i;
         K_XOR:   res_o = w_i ^ opnd_i;
         K_COM:   res_o = ~opnd_i;
         K_PASS:  res_o = opnd_i;
         K_TAKEW: res_o = w_i;
         K_SWAP:  res_o = {opnd_i[NIB-1:0], opnd_i[DATA_W-1:NIB]};
         K_RL: begin
            res_o = {opnd_i[DATA_W-2:0], c_i};
            c_o   = opnd_i[DATA_W-1];
         end
         K_RR: begin
            res_o = {c_i, opnd_i[DATA_W-1:1]};
            c_o   = opnd_i[0];
         end
         K_BCLR:  res_o = opnd_i & ~onehot;
         K_BSET:  res_o = opnd_i | onehot;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/base12_exec_alu.sv
module base12_exec_alu
   import base12_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int INSTR_W     = 12,
   parameter int ADDR_W      = 5,
   parameter int SPLIT_ADDER = 0
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  w_i,
   input  logic [DATA_W-1:0]  f_i,
   input  logic               c_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               dest_f_o,
   output logic               wr_en_o,
   output logic               c_o,
   output logic               dc_o,
   output logic               z_o,
   output logic [2:0]         flag_mask_o,
   output logic               non_alu_o
);

   localparam int BSEL_W = $clog2(DATA_W);

   if (DATA_W != 8 || ADDR_W != 5) begin : g_bad_cfg
      $error("base12_exec_alu: only DATA_W=8, ADDR_W=5 are supported");
   end

   dec_s              dec;
   logic [DATA_W-1:0] opnd, add_b, add_sum, lres;
   logic              add_cin, add_cout, add_half, lc, is_arith;

   base12_alu_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   assign opnd = dec.use_lit ? instr_i[DATA_W-1:0] : f_i;

   always_comb begin
      add_b    = '0;
      add_cin  = 1'b0;
      is_arith = 1'b1;
      unique case (dec.kind)
         K_ADD: add_b = w_i;
         K_SUB: begin add_b = ~w_i; add_cin = 1'b1; end
         K_INC: add_cin = 1'b1;
         K_DEC: add_b = '1;
         default: is_arith = 1'b0;
      endcase
   end

   base12_alu_addsub #(.DATA_W(DATA_W), .SPLIT_ADDER(SPLIT_ADDER)) u_add (
      .a_i    (f_i),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .half_o (add_half)
   );

   base12_alu_logic #(.DATA_W(DATA_W), .BSEL_W(BSEL_W)) u_log (
      .kind_i (dec.kind),
      .w_i    (w_i),
      .opnd_i (opnd),
      .c_i    (c_i),
      .bsel_i (instr_i[ADDR_W+BSEL_W-1:ADDR_W]),
      .res_o  (lres),
      .c_o    (lc)
   );

   always_comb begin
      result_o    = dec.non_alu ? '0 : (is_arith ? add_sum : lres);
      dest_f_o    = dec.dest_f;
      wr_en_o     = dec.wr_en;
      flag_mask_o = dec.mask;
      non_alu_o   = dec.non_alu;
      c_o  = dec.mask[FLG_C]  ? (is_arith ? add_cout : lc) : 1'b0;
      dc_o = dec.mask[FLG_DC] ? add_half : 1'b0;
      z_o  = dec.mask[FLG_Z]  ? (result_o == '0) : 1'b0;
   end

   always_comb begin
      if (!$isunknown({instr_i, w_i, f_i, c_i})) begin
         assert_nonalu_quiet_R10: assert (!non_alu_o ||
            (!wr_en_o && flag_mask_o == 3'b000 && result_o == '0));
         assert_sub_equal_noborrow_R2: assert (!(dec.kind == K_SUB && z_o) ||
            (c_o && dc_o));
         assert_bitop_single_R7: assert (!(dec.kind == K_BCLR || dec.kind == K_BSET) ||
            ($countones(result_o ^ f_i) <= 1));
         assert_rotate_conserve_R5: assert (!(dec.kind == K_RL || dec.kind == K_RR) ||
            ($countones(result_o) + int'(c_o) == $countones(f_i) + int'(c_i)));
      end
   end

endmodule

// File: tb/sim_base12_exec_alu.sv
module sim_base12_exec_alu;

   logic        clk = 1'b0;
   logic [11:0] instr;
   logic [7:0]  w, f;
   logic        c;
   logic [7:0]  result;
   logic        dest_f, wr_en, co, dco, zo, non_alu;
   logic [2:0]  mask;
   int          n_run = 0, n_fail = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   base12_exec_alu u0 (
      .instr_i (instr), .w_i (w), .f_i (f), .c_i (c),
      .result_o (result), .dest_f_o (dest_f), .wr_en_o (wr_en),
      .c_o (co), .dc_o (dco), .z_o (zo), .flag_mask_o (mask),
      .non_alu_o (non_alu)
   );

   // packing: {non_alu, wr_en, dest_f, mask[2:0], c, dc, z, result[7:0]}
   function automatic logic [16:0] model(logic [11:0] i, logic [7:0] wv,
                                         logic [7:0] fv, logic cv);
      logic na = 0, we = 0, ds = 0, fc = 0, fdc = 0;
      logic [2:0] mk = 0;
      logic [7:0] r = 0;
      logic [8:0] s;
      logic [7:0] lit = i[7:0];
      if (i == 12'h000) begin
         na = 0;
      end else if (i[11:5] == 7'b0000000) begin
         na = 1;
      end else if (i[11:5] == 7'b0000001) begin
         we = 1; ds = 1; r = wv;                                  // R9
      end else if (i[11:10] == 2'b00) begin
         we = 1; ds = i[5];
         case (i[11:6])
            6'b000001: begin r = 0; mk = 3'b001; end              // R9
            6'b000111: begin s = {1'b0, fv} + {1'b0, wv}; r = s[7:0];
                          fc = s[8]; fdc = ({1'b0, fv[3:0]} + {1'b0, wv[3:0]}) > 5'd15;
                          mk = 3'b111; end                        // R1
            6'b000010: begin s = {1'b0, fv} - {1'b0, wv}; r = s[7:0];
                          fc = !s[8]; fdc = fv[3:0] >= wv[3:0];
                          mk = 3'b111; end                        // R2
            6'b000100: begin r = wv | fv; mk = 3'b001; end
            6'b000101: begin r = wv & fv; mk = 3'b001; end
            6'b000110: begin r = wv ^ fv; mk = 3'b001; end
            6'b001000: begin r = fv;      mk = 3'b001; end
            6'b001001: begin r = ~fv;     mk = 3'b001; end
            6'b001010: begin r = fv + 8'd1; mk = 3'b001; end
            6'b000011: begin r = fv - 8'd1; mk = 3'b001; end      // R4
            6'b001100: begin r = {cv, fv[7:1]}; fc = fv[0]; mk = 3'b100; end
            6'b001101: begin r = {fv[6:0], cv}; fc = fv[7]; mk = 3'b100; end
            6'b001110: r = {fv[3:0], fv[7:4]};                    // R6
            default: begin na = 1; we = 0; ds = 0; end
         endcase
      end else begin
         case (i[11:8])
            4'b0100: begin we = 1; ds = 1; r = fv; r[i[7:5]] = 1'b0; end
            4'b0101: begin we = 1; ds = 1; r = fv; r[i[7:5]] = 1'b1; end
            4'b1100: begin we = 1; r = lit; end
            4'b1101: begin we = 1; r = wv | lit; mk = 3'b001; end
            4'b1110: begin we = 1; r = wv & lit; mk = 3'b001; end
            4'b1111: begin we = 1; r = wv ^ lit; mk = 3'b001; end
            default: na = 1;
         endcase
      end
      return {na, we, ds, mk, mk[2] & fc, mk[1] & fdc, mk[0] & (r == 8'h00), r};
   endfunction

   function automatic string req_of(logic [11:0] i);
      if (i[11:5] == 7'b0000001 || i[11:6] == 6'b000001) return "R9";
      if (i[11:6] == 6'b000111) return "R1";
      if (i[11:6] == 6'b000010) return "R2";
      if (i[11:6] == 6'b001100 || i[11:6] == 6'b001101) return "R5";
      if (i[11:6] == 6'b001110) return "R6";
      if (i[11:9] == 3'b010) return "R7";
      if (i[11:10] == 2'b11) return "R8";
      if (i[11:6] == 6'b001011 || i[11:6] == 6'b001111 || i[11:9] == 3'b011 ||
          i[11:10] == 2'b10 || i[11:5] == 7'b0000000) return "R10";
      return "R4/R3/R11";
   endfunction

   task automatic apply(logic [11:0] i, logic [7:0] wv, logic [7:0] fv, logic cv);
      logic [16:0] got, exp;
      @(negedge clk);
      instr = i; w = wv; f = fv; c = cv;
      #2;
      exp = model(i, wv, fv, cv);
      got = {non_alu, wr_en, dest_f, mask, co, dco, zo, result};
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%03h w=%02h f=%02h c=%0b got=%05h exp=%05h",
                  req_of(i), i, wv, fv, cv, got, exp);
      end
   endtask

   initial begin
      void'($urandom(32'h5A17));
      instr = 12'h000; w = 8'h00; f = 8'h00; c = 1'b0;
      apply(12'h000, 8'h00, 8'h00, 1'b0);        // R10 idle no-operation
      apply(12'h1E0, 8'h80, 8'h80, 1'b0);        // R1 carry and zero, no DC
      apply(12'h1C0, 8'h01, 8'h0F, 1'b0);        // R1 digit carry only, dest W (R3)
      apply(12'h0A0, 8'h37, 8'h37, 1'b0);        // R2 equal: C, DC, Z all set
      apply(12'h080, 8'h01, 8'h00, 1'b1);        // R2 borrow everywhere
      apply(12'h340, 8'h00, 8'h81, 1'b0);        // R5 rotate left, c in 0
      apply(12'h300, 8'h00, 8'h81, 1'b1);        // R5 rotate right, c in 1
      apply(12'h3A0, 8'h00, 8'hA5, 1'b1);        // R6 swap, no flags (R11)
      apply(12'h5E0, 8'h00, 8'h00, 1'b0);        // R7 set bit 7
      apply(12'h41F, 8'h00, 8'hFF, 1'b0);        // R7 clear bit 0
      apply(12'hC00, 8'h12, 8'h00, 1'b0);        // R8 load literal zero, no Z
      apply(12'hE0F, 8'hF0, 8'h00, 1'b0);        // R8 AND literal gives zero
      apply(12'h040, 8'h55, 8'h66, 1'b1);        // R9 clear W
      apply(12'h060, 8'h55, 8'h66, 1'b1);        // R9 clear file
      apply(12'h03F, 8'h9C, 8'h00, 1'b0);        // R9 copy W to file
      apply(12'h2A0, 8'h00, 8'hFF, 1'b1);        // R4 increment wraps to zero
      apply(12'h0C0, 8'h00, 8'h00, 1'b0);        // R4 decrement wraps, no C
      apply(12'h004, 8'h11, 8'h22, 1'b1);        // R10 special-register word
      apply(12'hA55, 8'h11, 8'h22, 1'b1);        // R10 branch word
      apply(12'h2C0, 8'h11, 8'h01, 1'b1);        // R10 skip-on-zero word
      for (int k = 0; k < 4000; k++)
         apply(12'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (200000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule